// File: doc/BRIEF.md
# PIO Mode to Clock Count Calculator

This block turns a requested IDE programmed-I/O transfer mode and a target cycle time into the three clock counts a host controller needs for one drive access: address setup clocks, strobe-active clocks and recovery clocks. It measures these counts in clocks of the bus that drives the controller. The bus frequency is an input in MHz, and the clock period is derived from it by integer division. Per-mode setup and active times come from a small internal table. Each count is a ceiling division of a time by the period. The results are then folded into the controller's legal range.

A request is accepted with a one-cycle `start` while the block is idle. The block runs five divisions one after another on a single shared bit-serial divider: the period, then setup, active, cycle and recovery-time counts. A combinational clamp stage then applies the floors, the spill of excess recovery into the active count, the caps and the revision-dependent recovery trim. The results appear on the count outputs together with a one-cycle `done` strobe. They stay there until the next result replaces them.

Top module: `pio_clock_calc`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `done` are 0 and all three count outputs are 0.
- R2: A mode value above 5 (the mode input is 3 bits wide) produces the same counts as mode 5.
- R3: A `bus_mhz` of 0 selects the parameter `DEFAULT_MHZ` (33 by default). The clock period in ns is floor(1000 / MHz).
- R4: The setup count is ceil(setup_ns / period). The table, as setup/active ns per mode 0..5, is 70/165, 50/125, 30/100, 30/80, 25/70 and 15/65.
- R5: The active count starts as ceil(active_ns / period), raised to at least 2. Its final value never exceeds 16.
- R6: Recovery is the larger of two terms, and is at least 2. The first term is ceil(max(cycle_ns − setup_ns − active_ns, 0) / period). The second is max(ceil(cycle_ns / period) − setup count − active count, 0), using the active count after its floor of 2.
- R7: If recovery exceeds 17, the excess is added to the active count and recovery becomes 17. The active count is capped at 16 after that.
- R8: When `rev` (2 bits) is greater than 1, recovery is reduced by one after the spill step. Recovery is then capped at 16.
- R9: `done` is high for exactly one clock per accepted request. `busy` is high from the clock after `start` is accepted until `done`. The count outputs change only in the clock where `done` is high.
- R10: `start` pulses received while `busy` is high are ignored and do not affect the result of the request in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| pio_mode | input | 3 | Requested transfer mode, values above 5 treated as 5 |
| cycle_ns | input | CYC_W | Target cycle time in ns |
| bus_mhz | input | MHZ_W | Bus clock in MHz, 0 selects the default |
| rev | input | 2 | Controller revision; above 1 trims recovery by one |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock result strobe |
| setup_cnt | output | 5 | Address setup clocks |
| active_cnt | output | 5 | Strobe-active clocks |
| recovery_cnt | output | 5 | Recovery clocks |

## Verification
The bench uses directed corner cases and seeded random requests. It compares every result against a reference model written from the requirements. The directed cases are chosen so that each can only pass if one specific rule works. A fast mode at the default bus speed lands on the recovery floor. A long cycle on a fast bus forces the spill into the active count and hits the active cap. Out-of-range mode codes must equal mode 5, and the same request with newer and older revision values separates the recovery trim. Random requests cover every mode, bus speeds from 0 to 255 MHz and cycle times up to the input width, which exercises both recovery terms winning. Extra `start` pulses, carrying different operands, are sent in the middle of some requests to show they are ignored.

// File: rtl/pio_calc_pkg.sv
// Package: shared constants and types for the PIO clock count calculator.
// Assumes the controller limits below are fixed properties of the target.
package pio_calc_pkg;
    localparam int MODE_W    = 3;
    localparam int MAX_MODE  = 5;
    localparam int OUT_W     = 5;
    localparam int ACT_MIN   = 2;
    localparam int ACT_MAX   = 16;
    localparam int REC_MIN   = 2;
    localparam int REC_SPILL = 17;
    localparam int REC_MAX   = 16;
    localparam int NS_PER_US = 1000;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LAUNCH,
        S_WAIT,
        S_DONE
    } calc_state_e;

    typedef enum logic [2:0] {
        P_PERIOD,
        P_SETUP,
        P_ACTIVE,
        P_CYCLE,
        P_RECOV
    } calc_step_e;

    typedef struct packed {
        logic [7:0] setup_ns;
        logic [7:0] active_ns;
    } mode_time_t;
endpackage

// File: rtl/pio_calc_rom.sv
// Module: per-mode timing table (setup and active ns).
// Assumes the mode is already limited to 0..MAX_MODE; other codes read mode 5.
module pio_calc_rom
    import pio_calc_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output mode_time_t        times
);
    // Table lookup by mode.
    always_comb begin
        case (mode)
            3'd0:    times = '{setup_ns: 8'd70, active_ns: 8'd165};
            3'd1:    times = '{setup_ns: 8'd50, active_ns: 8'd125};
            3'd2:    times = '{setup_ns: 8'd30, active_ns: 8'd100};
            3'd3:    times = '{setup_ns: 8'd30, active_ns: 8'd80};
            3'd4:    times = '{setup_ns: 8'd25, active_ns: 8'd70};
            default: times = '{setup_ns: 8'd15, active_ns: 8'd65};
        endcase
    end
endmodule

// File: rtl/pio_calc_div.sv
// Module: bit-serial restoring divider, one quotient bit per clock.
// Takes NW+1 clocks from start to the done pulse. Assumes den is non-zero;
// start is taken only when idle.
module pio_calc_div #(
    parameter int NW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [NW-1:0] den,
    output logic          done,
    output logic [NW-1:0] quo
);
    localparam int CW = $clog2(NW + 1);

    logic [NW-1:0] q_r, rem_r, den_r, num_r;
    logic [CW-1:0] cnt_r;
    logic          run_r, done_r;
    logic [NW:0]   shifted, trial;
    logic          fits;

    // Partial remainder step: shift in the next dividend bit and try a subtract.
    always_comb begin
        shifted = {rem_r, q_r[NW-1]};
        trial   = shifted - {1'b0, den_r};
        fits    = shifted >= {1'b0, den_r};
    end

    // Iteration state: load on start, then one quotient bit per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r    <= '0;
            rem_r  <= '0;
            den_r  <= '0;
            num_r  <= '0;
            cnt_r  <= '0;
            run_r  <= 1'b0;
            done_r <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (start && !run_r) begin
                q_r   <= num;
                num_r <= num;
                rem_r <= '0;
                den_r <= den;
                cnt_r <= CW'(NW);
                run_r <= 1'b1;
            end else if (run_r) begin
                q_r   <= {q_r[NW-2:0], fits};
                rem_r <= fits ? trial[NW-1:0] : shifted[NW-1:0];
                cnt_r <= cnt_r - 1'b1;
                if (cnt_r == CW'(1)) begin
                    run_r  <= 1'b0;
                    done_r <= 1'b1;
                end
            end
        end
    end

    assign done = done_r;
    assign quo  = q_r;

    // R4: a finished division reconstructs its dividend exactly.
    a_r4_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
        done_r |-> ((2*NW)'(q_r) * (2*NW)'(den_r) + (2*NW)'(rem_r) == (2*NW)'(num_r))
                   && (rem_r < den_r));
endmodule

// File: rtl/pio_calc_clamp.sv
// Module: folds the raw ceiling counts into the controller's legal range.
// Purely combinational. Assumes the inputs are the raw ceiling counts.
module pio_calc_clamp
    import pio_calc_pkg::*;
#(
    parameter int NW = 13
) (
    input  logic [NW-1:0]    setup_c,
    input  logic [NW-1:0]    act_c,
    input  logic [NW-1:0]    cyc_c,
    input  logic [NW-1:0]    rect_c,
    input  logic             newer,
    output logic [OUT_W-1:0] act_o,
    output logic [OUT_W-1:0] rec_o
);
    localparam int XW = NW + 2;

    logic [XW-1:0] a1, sa, rec2, r1, r2, r3, a2, a3, r4;

    // Floor, spill, cap and revision trim in the fixed order of the rules.
    always_comb begin
        a1   = (XW'(act_c) < XW'(ACT_MIN)) ? XW'(ACT_MIN) : XW'(act_c);
        sa   = XW'(setup_c) + a1;
        rec2 = (XW'(cyc_c) > sa) ? XW'(cyc_c) - sa : '0;
        r1   = (XW'(rect_c) > rec2) ? XW'(rect_c) : rec2;
        r2   = (r1 < XW'(REC_MIN)) ? XW'(REC_MIN) : r1;
        if (r2 > XW'(REC_SPILL)) begin
            a2 = a1 + (r2 - XW'(REC_SPILL));
            r3 = XW'(REC_SPILL);
        end else begin
            a2 = a1;
            r3 = r2;
        end
        a3 = (a2 > XW'(ACT_MAX)) ? XW'(ACT_MAX) : a2;
        r4 = newer ? r3 - 1'b1 : r3;
        if (r4 > XW'(REC_MAX)) r4 = XW'(REC_MAX);
        act_o = a3[OUT_W-1:0];
        rec_o = r4[OUT_W-1:0];
    end
endmodule

// File: rtl/pio_clock_calc.sv
// Module: top of the PIO clock count calculator.
// Sequences five divisions on one shared divider, then clamps and publishes.
// Assumes MHZ_W <= 8, so the period is at least 3 ns and never zero, and
// CYC_W >= 10.
module pio_clock_calc
    import pio_calc_pkg::*;
#(
    parameter int CYC_W       = 11,
    parameter int MHZ_W       = 8,
    parameter int DEFAULT_MHZ = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       pio_mode,
    input  logic [CYC_W-1:0] cycle_ns,
    input  logic [MHZ_W-1:0] bus_mhz,
    input  logic [1:0]       rev,
    output logic             busy,
    output logic             done,
    output logic [4:0]       setup_cnt,
    output logic [4:0]       active_cnt,
    output logic [4:0]       recovery_cnt
);
    localparam int NW = (CYC_W >= 10) ? CYC_W + 2 : 12;

    calc_state_e       state_q;
    calc_step_e        step_q;
    logic [2:0]        mode_q;
    logic [CYC_W-1:0]  cycle_q;
    logic [MHZ_W-1:0]  mhz_q;
    logic              newer_q;
    logic [NW-1:0]     per_q, setc_q, actc_q, cycc_q;
    logic              done_q;
    logic [OUT_W-1:0]  set_o_q, act_o_q, rec_o_q;

    mode_time_t        times;
    logic [NW-1:0]     sum_ns, rec_ns, dnum, dden, dquo, time_sel;
    logic              dstart, ddone;
    logic [OUT_W-1:0]  act_cl, rec_cl;

    pio_calc_rom u_rom (
        .mode  (mode_q),
        .times (times)
    );

    // Recovery time left after setup and active, floored at zero.
    always_comb begin
        sum_ns = NW'(times.setup_ns) + NW'(times.active_ns);
        rec_ns = (NW'(cycle_q) > sum_ns) ? NW'(cycle_q) - sum_ns : '0;
    end

    // Divider operands for the current step.
    always_comb begin
        case (step_q)
            P_SETUP:  time_sel = NW'(times.setup_ns);
            P_ACTIVE: time_sel = NW'(times.active_ns);
            P_CYCLE:  time_sel = NW'(cycle_q);
            default:  time_sel = rec_ns;
        endcase
        if (step_q == P_PERIOD) begin
            dnum = NW'(NS_PER_US);
            dden = NW'(mhz_q);
        end else begin
            dnum = time_sel + per_q - 1'b1;
            dden = per_q;
        end
        dstart = (state_q == S_LAUNCH);
    end

    pio_calc_div #(.NW(NW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (dstart),
        .num   (dnum),
        .den   (dden),
        .done  (ddone),
        .quo   (dquo)
    );

    pio_calc_clamp #(.NW(NW)) u_clamp (
        .setup_c (setup_c_w),
        .act_c   (actc_q),
        .cyc_c   (cycc_q),
        .rect_c  (dquo),
        .newer   (newer_q),
        .act_o   (act_cl),
        .rec_o   (rec_cl)
    );

    logic [NW-1:0] setup_c_w;
    assign setup_c_w = setc_q;

    // Request sequencing: latch, five divisions, clamp and publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= P_PERIOD;
            mode_q  <= '0;
            cycle_q <= '0;
            mhz_q   <= '0;
            newer_q <= 1'b0;
            per_q   <= '0;
            setc_q  <= '0;
            actc_q  <= '0;
            cycc_q  <= '0;
            done_q  <= 1'b0;
            set_o_q <= '0;
            act_o_q <= '0;
            rec_o_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        mode_q  <= (pio_mode > 3'(MAX_MODE)) ? 3'(MAX_MODE) : pio_mode;
                        cycle_q <= cycle_ns;
                        mhz_q   <= (bus_mhz == '0) ? MHZ_W'(DEFAULT_MHZ) : bus_mhz;
                        newer_q <= (rev > 2'd1);
                        step_q  <= P_PERIOD;
                        state_q <= S_LAUNCH;
                    end
                end
                S_LAUNCH: state_q <= S_WAIT;
                S_WAIT: begin
                    if (ddone) begin
                        case (step_q)
                            P_PERIOD: per_q  <= dquo;
                            P_SETUP:  setc_q <= dquo;
                            P_ACTIVE: actc_q <= dquo;
                            P_CYCLE:  cycc_q <= dquo;
                            default:  ;
                        endcase
                        if (step_q == P_RECOV) begin
                            state_q <= S_DONE;
                        end else begin
                            step_q  <= calc_step_e'(step_q + 3'd1);
                            state_q <= S_LAUNCH;
                        end
                    end
                end
                default: begin
                    set_o_q <= setc_q[OUT_W-1:0];
                    act_o_q <= act_cl;
                    rec_o_q <= rec_cl;
                    done_q  <= 1'b1;
                    state_q <= S_IDLE;
                end
            endcase
        end
    end

    assign busy         = (state_q != S_IDLE);
    assign done         = done_q;
    assign setup_cnt    = set_o_q;
    assign active_cnt   = act_o_q;
    assign recovery_cnt = rec_o_q;

    // R9: the result strobe lasts one clock.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R9: counts only move in the strobe clock.
    a_r9_counts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> ($stable(set_o_q) && $stable(act_o_q) && $stable(rec_o_q)));

    // R5: published active count lies in its legal range.
    a_r5_active_range: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (act_o_q >= OUT_W'(ACT_MIN)) && (act_o_q <= OUT_W'(ACT_MAX)));

    // R8: recovery stays within 1..16, and within 2..16 for older revisions.
    a_r8_recovery_range: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (rec_o_q <= OUT_W'(REC_MAX)) && (rec_o_q >= 1)
                   && (newer_q || rec_o_q >= OUT_W'(REC_MIN)));

    // R10: latched operands do not move while a request is in flight.
    a_r10_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> ($stable(mode_q) && $stable(cycle_q)
                                 && $stable(mhz_q) && $stable(newer_q)));

    // R4: setup count fits the output width.
    a_r4_setup_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE) |-> (setc_q < NW'(32)));
endmodule

// File: tb/tb_pio_clock_calc.sv
module tb_pio_clock_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  pio_mode = '0;
    logic [10:0] cycle_ns = '0;
    logic [7:0]  bus_mhz = '0;
    logic [1:0]  rev = '0;
    logic        busy, done;
    logic [4:0]  setup_cnt, active_cnt, recovery_cnt;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pio_clock_calc dut (
        .clk (clk), .rst_n (rst_n), .start (start), .pio_mode (pio_mode),
        .cycle_ns (cycle_ns), .bus_mhz (bus_mhz), .rev (rev), .busy (busy),
        .done (done), .setup_cnt (setup_cnt), .active_cnt (active_cnt),
        .recovery_cnt (recovery_cnt)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model written from R2..R8.
    function automatic void ref_counts(input int m, input int cyc, input int mhz,
                                       input int rv, output int s, output int a,
                                       output int r);
        int su, ac, per, c, rt, r2;
        if (m > 5) m = 5;                                   // R2
        case (m)
            0: begin su = 70; ac = 165; end
            1: begin su = 50; ac = 125; end
            2: begin su = 30; ac = 100; end
            3: begin su = 30; ac = 80;  end
            4: begin su = 25; ac = 70;  end
            default: begin su = 15; ac = 65; end
        endcase
        if (mhz == 0) mhz = 33;                             // R3
        per = 1000 / mhz;
        s = (su + per - 1) / per;                           // R4
        a = (ac + per - 1) / per;
        c = (cyc + per - 1) / per;
        rt = (cyc > su + ac) ? (cyc - su - ac + per - 1) / per : 0;
        if (a < 2) a = 2;                                   // R5
        r2 = (c > s + a) ? c - s - a : 0;                   // R6
        r = (rt > r2) ? rt : r2;
        if (r < 2) r = 2;
        if (r > 17) begin a = a + r - 17; r = 17; end       // R7
        if (a > 16) a = 16;
        if (rv > 1) r = r - 1;                              // R8
        if (r > 16) r = 16;
    endfunction

    task automatic run_case(input int m, input int cyc, input int mhz, input int rv,
                            input string tag, input bit junk);
        int s, a, r, n;
        ref_counts(m, cyc, mhz, rv, s, a, r);
        @(negedge clk);
        pio_mode = 3'(m); cycle_ns = 11'(cyc); bus_mhz = 8'(mhz); rev = 2'(rv);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R9 busy after start"}, busy, 1);
        if (junk) begin
            // R10: a second request while busy with different operands
            repeat (3) @(negedge clk);
            pio_mode = 3'(m ^ 3); cycle_ns = 11'(cyc ^ 11'h2A5); bus_mhz = 8'(mhz + 77);
            rev = 2'(rv ^ 2);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            check({tag, " R9 done timeout"}, 0, 1);
        end else begin
            check({tag, " R4 setup"}, setup_cnt, s);
            check({tag, " R5/R7 active"}, active_cnt, a);
            check({tag, " R6/R8 recovery"}, recovery_cnt, r);
            @(negedge clk);
            check({tag, " R9 done single"}, done, 0);
            check({tag, " R9 counts held"}, recovery_cnt, r);
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 setup", setup_cnt, 0);
        check("R1 active", active_cnt, 0);
        check("R1 recovery", recovery_cnt, 0);
        @(negedge clk);
        rst_n = 1'b1;
        run_case(4, 120, 0, 0, "R3 default bus, R6 floor", 0);
        run_case(4, 120, 33, 0, "R3 explicit 33", 0);
        run_case(0, 600, 33, 0, "R4 mode0", 0);
        run_case(0, 2000, 255, 0, "R7 spill and cap", 0);
        run_case(0, 2000, 255, 2, "R8 trim with spill", 0);
        run_case(2, 240, 50, 3, "R8 newer", 0);
        run_case(2, 240, 50, 1, "R8 older", 0);
        run_case(7, 100, 50, 0, "R2 mode7", 0);
        run_case(6, 100, 50, 0, "R2 mode6", 0);
        run_case(5, 100, 50, 0, "R2 mode5", 0);
        run_case(3, 180, 1, 0, "R3 1 MHz", 0);
        run_case(1, 383, 33, 0, "R10 start while busy", 1);
        for (int i = 0; i < 150; i++) begin
            run_case(int'($urandom % 8), int'($urandom % 2048), int'($urandom % 256),
                     int'($urandom % 4), "random", (i % 5) == 0);
        end
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule